// File: doc/BRIEF.md
# Sample Rate Class Detector

This block sorts an incoming audio stream into a high-rate class (around 88.2 kHz and above) or a normal-rate class. It does so by counting cycles of a fixed reference clock between consecutive frame strobes. The resulting period count is compared against two separate thresholds. A short period (high rate) sets the class flag, a long period (low rate) clears it, and any period in the band between the two leaves the flag where it was. This hysteresis keeps the indication steady when the rate sits between the thresholds.

A measurement is only accepted when the receiver reports lock and the period lies inside the span that corresponds to 22 kHz to 108 kHz. Otherwise the flag is left alone and an out-of-range indication is raised. The period counter saturates when strobes stop arriving, so a missing input is reported as out of range. When the receiver runs from its crystal, the class output is taken from a software-set bit instead. The measurement keeps running underneath, so the measured class reappears as soon as crystal mode is left.

All thresholds are derived at elaboration time from the reference frequency parameter. The numbers below assume the default of 10 MHz.

Top module: `rate_class_det`

## Requirements
- R1: After reset, `high_rate_o` is 0 (with `xtal_mode_i` low), `period_o` is 0 and `out_of_range_o` is 1.
- R2: `period_o` shows the number of reference clocks from one sampled strobe to the next. A strobe sampled at edge t+N after one at edge t gives N, visible after edge t+N.
- R3: With lock high, a measured period of at most 113 clocks (rate of 88.2 kHz or more) sets the measured class to 1.
- R4: With lock high, a measured period of at least 186 clocks (rate of 54 kHz or less) clears the measured class to 0.
- R5: With lock high, a measured period from 114 to 185 clocks leaves the measured class unchanged.
- R6: A period below 93 or above 454 clocks, or a strobe sampled while `lock_i` is low, leaves the measured class unchanged and sets `out_of_range_o`. A valid measurement clears `out_of_range_o`.
- R7: When 455 clocks pass without a strobe, the counter saturates. `period_o` becomes 455 and `out_of_range_o` becomes 1. The first strobe after reset is also out of range.
- R8: While `xtal_mode_i` is 1, `high_rate_o` equals `xtal_hi_i` combinationally. Measurement continues, and when the mode returns to 0 the output shows the measured class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | One-cycle frame strobe, synchronous to clk_i |
| lock_i | input | 1 | Receiver lock indication |
| xtal_mode_i | input | 1 | 1 selects the override bit as the output |
| xtal_hi_i | input | 1 | Software-set class used in crystal mode |
| high_rate_o | output | 1 | High-rate class flag |
| period_o | output | CW | Last measured period in reference clocks |
| out_of_range_o | output | 1 | Last measurement rejected or input missing |

## Verification
The bench sends strobe trains whose periods walk the class flag through rise, fall and hold. This separates true hysteresis from a single-threshold design. Periods are placed exactly on and one clock beside each threshold and each range limit, which exposes off-by-one comparisons. Unlocked strobes, over-long gaps that saturate the counter, and too-short periods each show whether a rejected measurement disturbs the flag. Toggling crystal mode with both override values, while measurements continue, shows that the override masks the output without stopping the measurement.

// File: rtl/rate_class_det.sv
module rate_class_det #(
  parameter int REF_HZ      = 10_000_000,
  parameter int RISE_HZ     = 88_200,
  parameter int FALL_HZ     = 54_000,
  parameter int MIN_RATE_HZ = 22_000,
  parameter int MAX_RATE_HZ = 108_000,
  localparam int HI_MAX  = REF_HZ / RISE_HZ,
  localparam int LO_MIN  = (REF_HZ + FALL_HZ - 1) / FALL_HZ,
  localparam int CNT_MIN = (REF_HZ + MAX_RATE_HZ - 1) / MAX_RATE_HZ,
  localparam int CNT_MAX = REF_HZ / MIN_RATE_HZ,
  localparam int SAT     = CNT_MAX + 1,
  localparam int CW      = $clog2(SAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic          lock_i,
  input  logic          xtal_mode_i,
  input  logic          xtal_hi_i,
  output logic          high_rate_o,
  output logic [CW-1:0] period_o,
  output logic          out_of_range_o
);

  localparam logic [CW-1:0] SAT_C  = CW'(SAT);
  localparam logic [CW-1:0] HI_C   = CW'(HI_MAX);
  localparam logic [CW-1:0] LO_C   = CW'(LO_MIN);
  localparam logic [CW-1:0] MIN_C  = CW'(CNT_MIN);
  localparam logic [CW-1:0] MAX_C  = CW'(CNT_MAX);

  logic [CW-1:0] cnt;
  logic          meas_hi;

  wire in_range = (cnt >= MIN_C) && (cnt <= MAX_C);
  wire accept   = strobe_i && lock_i && in_range;
  wire go_hi    = accept && (cnt <= HI_C);
  wire go_lo    = accept && (cnt >= LO_C);
  wire sat_now  = !strobe_i && (cnt == SAT_C - CW'(1));

  assign high_rate_o = xtal_mode_i ? xtal_hi_i : meas_hi;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt            <= SAT_C;
      meas_hi        <= 1'b0;
      period_o       <= '0;
      out_of_range_o <= 1'b1;
    end else begin
      if (strobe_i) begin
        cnt            <= CW'(1);
        period_o       <= cnt;
        out_of_range_o <= !accept;
      end else if (cnt != SAT_C) begin
        cnt <= cnt + CW'(1);
      end
      if (sat_now) begin
        period_o       <= SAT_C;
        out_of_range_o <= 1'b1;
      end
      if (go_hi)      meas_hi <= 1'b1;
      else if (go_lo) meas_hi <= 1'b0;
    end
  end

  p_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && lock_i && cnt >= MIN_C && cnt <= HI_C) |=> meas_hi);

  p_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && lock_i && cnt >= LO_C && cnt <= MAX_C) |=> !meas_hi);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && lock_i && cnt > HI_C && cnt < LO_C) |=> $stable(meas_hi));

  p_unlocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !lock_i) |=> ($stable(meas_hi) && out_of_range_o));

  p_saturate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && cnt == SAT_C - CW'(1)) |=> (period_o == SAT_C && out_of_range_o));

endmodule

// File: tb/rate_class_det_tb.sv
module rate_class_det_tb;
  localparam int CW = 9;

  logic clk = 0, rst_n = 0, strobe = 0, lock = 1, xmode = 0, xhi = 0;
  logic hr, oor;
  logic [CW-1:0] per;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rate_class_det u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .lock_i(lock),
    .xtal_mode_i(xmode), .xtal_hi_i(xhi),
    .high_rate_o(hr), .period_o(per), .out_of_range_o(oor));

  int m_cnt, m_per, m_hi, m_oor;
  always @(posedge clk) begin
    real rate;
    if (!rst_n) begin
      m_cnt = 455; m_per = 0; m_hi = 0; m_oor = 1;
    end else if (strobe) begin
      rate  = 10.0e6 / m_cnt;
      m_per = m_cnt;
      if (lock && rate >= 22000.0 && rate <= 108000.0) begin
        m_oor = 0;
        if (rate >= 88200.0) m_hi = 1;
        else if (rate <= 54000.0) m_hi = 0;
      end else m_oor = 1;
      m_cnt = 1;
    end else if (m_cnt < 455) begin
      m_cnt++;
      if (m_cnt == 455) begin m_per = 455; m_oor = 1; end
    end
  end

  function automatic void chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    chk("R8 class vs model", hr, xmode ? xhi : m_hi);
    chk("R2 period vs model", per, m_per);
    chk("R6 range flag vs model", oor, m_oor);
  end

  task automatic frame(int n);
    repeat (n - 1) @(negedge clk);
    strobe = 1;
    @(negedge clk);
    strobe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset class", hr, 0);
    chk("R1 reset period", per, 0);
    chk("R1 reset range", oor, 1);
    rst_n = 1;
    frame(1);
    chk("R7 first strobe out of range", oor, 1);
    frame(200); chk("R4 period 200", hr, 0); chk("R2 period 200", per, 200);
    frame(100); chk("R3 period 100", hr, 1); chk("R6 valid clears flag", oor, 0);
    frame(150); chk("R5 hold high", hr, 1);
    frame(200); chk("R4 fall", hr, 0);
    frame(150); chk("R5 hold low", hr, 0);
    frame(114); chk("R5 edge 114 holds", hr, 0);
    frame(113); chk("R3 edge 113", hr, 1);
    frame(185); chk("R5 edge 185 holds", hr, 1);
    frame(186); chk("R4 edge 186", hr, 0);
    frame(92);  chk("R6 short 92 ignored", hr, 0); chk("R6 short flag", oor, 1);
    frame(93);  chk("R3 edge 93 valid", hr, 1); chk("R6 93 in range", oor, 0);
    frame(454); chk("R4 edge 454 valid", hr, 0); chk("R6 454 in range", oor, 0);
    frame(100); chk("R3 back high", hr, 1);
    lock = 0;
    frame(200); chk("R6 unlocked ignored", hr, 1); chk("R6 unlocked flag", oor, 1);
    lock = 1;
    repeat (460) @(negedge clk);
    chk("R7 saturated period", per, 455); chk("R7 saturated flag", oor, 1);
    chk("R7 class kept", hr, 1);
    frame(1); chk("R7 strobe after gap", oor, 1); chk("R7 class still kept", hr, 1);
    xmode = 1; xhi = 0;
    @(negedge clk); chk("R8 override low", hr, 0);
    xhi = 1;
    @(negedge clk); chk("R8 override high", hr, 1);
    xhi = 0;
    frame(200); frame(200);
    chk("R8 override masks measurement", hr, 0);
    xhi = 1;
    frame(100);
    xmode = 0;
    @(negedge clk); chk("R8 measured restored", hr, 1);
    frame(300); chk("R4 period 300", hr, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule